// File: doc/BRIEF.md
# Serial Port Register Bank with Interrupt Logic

This block sits between a processor bus and the character-level datapath of a 16450-compatible serial port. It decodes a 3-bit register offset with single-cycle byte read and write strobes. It holds the baud divisor, interrupt enable, line control, modem control, modem status and scratch registers. It drives a single level interrupt line from a two-source priority encoder.

Outgoing characters are handed to an external transmitter through a valid/ready handshake. Incoming characters and break events arrive on a receive strobe, which the block accepts only while its one-byte receive buffer is empty.

The line-status byte reports data ready, break, holding-register empty and transmitter empty. In loopback mode the modem-control outputs are folded back into the modem-status read value.

Top module: `uart_regif`

## Requirements
- R1: Only addr[2:0] is decoded. With line-control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. In that state the interrupt-enable register is untouched and no character is sent. With bit 7 clear, offset 1 is the interrupt-enable register.
- R2: Reading offset 2 returns the interrupt identity: 0x01 when nothing is pending, 0x02 for transmit-holding-empty, and 0x04 for received data. Received data wins when both sources are pending.
- R3: Received data is pending when line-status bit 0 and enable bit 0 are both 1. Transmit-empty is pending when the internal transmit-pending flag and enable bit 1 are both 1. irq is high exactly when the identity is not 0x01. The pending flag is 0 after reset.
- R4: A read of offset 2 that returns 0x02 clears the transmit-pending flag, so the next identity read no longer reports 0x02.
- R5: A data write (offset 0, line-control bit 7 clear) clears the transmit-pending flag and line-status bit 5, and it presents the byte on tx_data with tx_valid. When the transmitter accepts the byte, bits 5 and 6 and the pending flag are set.
- R6: tx_valid and tx_data stay unchanged until tx_ready is seen. Line-status bit 5 is 0 during that whole time. A data write made while tx_valid is high is dropped.
- R7: A read of offset 0 with line-control bit 7 clear returns the receive buffer and clears line-status bits 0 and 4.
- R8: rx_ready equals the inverse of line-status bit 0. An accepted byte loads the buffer and sets bit 0. An accepted break loads 0x00 and sets bits 0 and 4. rx_valid while bit 0 is set has no effect.
- R9: With modem-control bit 4 set, a read of offset 6 returns control bits 3,2,1,0 in status bits 7,6,4,5 with the other bits 0. Otherwise it returns the stored modem-status byte.
- R10: After reset, line status reads 0x60, identity reads 0x01, irq, tx_valid and all read/write registers are 0, and rx_ready is 1.
- R11: Writes to offsets 2 and 5 have no effect. Offsets 3, 4, 6 and 7 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; read side effects occur at the end of this cycle |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_valid | input | 1 | Receive event strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Receive event is a break |
| rx_ready | output | 1 | Receive buffer can take an event |

## Verification
The transmit path is exercised in three ways. A stalled transmitter shows that the byte is held, that THRE stays low and that a second write is dropped. A transmitter that is always ready shows a one-cycle handoff. Back-to-back identity reads separate the raised flag from its clear-on-read. Receive stimulus uses an ordinary byte, a byte sent into a full buffer, and a break, so the stored byte, the ignored byte and the break flag can each be seen. The two interrupt sources are made pending together to expose the priority. Loopback is tried with several modem-control patterns, chosen so that a swapped bit mapping shows up as a wrong status value.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DATA  = 3'd0,
    OFF_IEN   = 3'd1,
    OFF_IID   = 3'd2,
    OFF_LCTL  = 3'd3,
    OFF_MCTL  = 3'd4,
    OFF_LSTAT = 3'd5,
    OFF_MSTAT = 3'd6,
    OFF_SCR   = 3'd7
  } reg_off_e;

  localparam logic [BYTE_W-1:0] IID_NONE = 8'h01;
  localparam logic [BYTE_W-1:0] IID_THR  = 8'h02;
  localparam logic [BYTE_W-1:0] IID_RXD  = 8'h04;

  localparam int LCTL_DIVSEL = 7;
  localparam int MCTL_LOOP   = 4;
  localparam int IEN_RX      = 0;
  localparam int IEN_TX      = 1;

  // Priority encoder: receive data first, transmit-empty second.
  function automatic logic [BYTE_W-1:0] pick_iid(input logic rx_src, input logic tx_src);
    if (rx_src)      return IID_RXD;
    else if (tx_src) return IID_THR;
    else             return IID_NONE;
  endfunction

  // Line-status byte assembly: bit0 ready, bit4 break, bit5 holding empty, bit6 shifter empty.
  function automatic logic [BYTE_W-1:0] pack_lstat(input logic dr, input logic bi,
                                                   input logic thre, input logic temt);
    return {1'b0, temt, thre, bi, 3'b000, dr};
  endfunction

  // Loopback fold of control outputs into status inputs.
  function automatic logic [BYTE_W-1:0] loop_status(input logic [BYTE_W-1:0] mctl);
    return {mctl[3], mctl[2], mctl[0], mctl[1], 4'b0000};
  endfunction
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_break,
  input  logic              rd_buf,
  output logic [BYTE_W-1:0] buf_q,
  output logic              dr_q,
  output logic              bi_q,
  output logic              rx_take
);
  assign rx_take = rx_valid & ~dr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      dr_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else if (rx_take) begin
      buf_q <= rx_break ? '0 : rx_data;
      dr_q  <= 1'b1;
      bi_q  <= rx_break;
    end else if (rd_buf) begin
      dr_q  <= 1'b0;
      bi_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_char,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              iid_ack,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              thre_q,
  output logic              temt_q,
  output logic              pend_q,
  output logic              tx_accept
);
  logic wr_go;
  assign wr_go     = wr_char & ~tx_valid;
  assign tx_accept = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      thre_q   <= 1'b1;
      temt_q   <= 1'b1;
      pend_q   <= 1'b0;
    end else if (wr_go) begin
      tx_valid <= 1'b1;
      tx_data  <= wdata;
      thre_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else if (tx_accept) begin
      tx_valid <= 1'b0;
      thre_q   <= 1'b1;
      temt_q   <= 1'b1;
      pend_q   <= 1'b1;
    end else if (iid_ack) begin
      pend_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_regif_pkg::*;
(
  input  logic [BYTE_W-1:0] ien,
  input  logic              dr,
  input  logic              tx_pend,
  output logic [BYTE_W-1:0] iid,
  output logic              irq
);
  logic rx_src, tx_src;
  assign rx_src = dr & ien[IEN_RX];
  assign tx_src = tx_pend & ien[IEN_TX];
  assign iid    = pick_iid(rx_src, tx_src);
  assign irq    = (iid != IID_NONE);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rx_ready
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0]  div_q;
  logic [BYTE_W-1:0] ien_q, lctl_q, mctl_q, mstat_q, scr_q;
  logic [BYTE_W-1:0] rbuf, iid, lstat;
  logic dr, bi, thre, temt, tx_pend, tx_accept, rx_take;
  logic divsel, loop_on;
  logic wr_char, rd_buf, iid_ack;
  reg_off_e off;

  assign off     = reg_off_e'(addr);
  assign divsel  = lctl_q[LCTL_DIVSEL];
  assign loop_on = mctl_q[MCTL_LOOP];
  assign wr_char = wr_en & (off == OFF_DATA) & ~divsel;
  assign rd_buf  = rd_en & (off == OFF_DATA) & ~divsel;
  assign iid_ack = rd_en & (off == OFF_IID) & (iid == IID_THR);
  assign lstat   = pack_lstat(dr, bi, thre, temt);
  assign rx_ready = ~dr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ien_q   <= '0;
      lctl_q  <= '0;
      mctl_q  <= '0;
      mstat_q <= '0;
      scr_q   <= '0;
    end else if (wr_en) begin
      case (off)
        OFF_DATA:  if (divsel) div_q[BYTE_W-1:0] <= wdata;
        OFF_IEN:   if (divsel) div_q[DIV_W-1:BYTE_W] <= wdata;
                   else        ien_q <= wdata;
        OFF_LCTL:  lctl_q  <= wdata;
        OFF_MCTL:  mctl_q  <= wdata;
        OFF_MSTAT: mstat_q <= wdata;
        OFF_SCR:   scr_q   <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (off)
      OFF_DATA:  rdata = divsel ? div_q[BYTE_W-1:0] : rbuf;
      OFF_IEN:   rdata = divsel ? div_q[DIV_W-1:BYTE_W] : ien_q;
      OFF_IID:   rdata = iid;
      OFF_LCTL:  rdata = lctl_q;
      OFF_MCTL:  rdata = mctl_q;
      OFF_LSTAT: rdata = lstat;
      OFF_MSTAT: rdata = loop_on ? loop_status(mctl_q) : mstat_q;
      default:   rdata = scr_q;
    endcase
  end

  uart_rx_hold u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rd_buf(rd_buf), .buf_q(rbuf), .dr_q(dr),
    .bi_q(bi), .rx_take(rx_take)
  );

  uart_tx_hold u_tx (
    .clk(clk), .rst_n(rst_n), .wr_char(wr_char), .wdata(wdata),
    .iid_ack(iid_ack), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .thre_q(thre), .temt_q(temt), .pend_q(tx_pend),
    .tx_accept(tx_accept)
  );

  uart_irq_gen u_irq (
    .ien(ien_q), .dr(dr), .tx_pend(tx_pend), .iid(iid), .irq(irq)
  );
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_buf,
  input logic              iid_ack,
  input logic              rx_take,
  input logic              rx_break,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_accept,
  input logic              dr,
  input logic              bi,
  input logic              thre,
  input logic              tx_pend,
  input logic [BYTE_W-1:0] rbuf,
  input logic [BYTE_W-1:0] iid,
  input logic [BYTE_W-1:0] ien
);
  // R2: receive source dominates the encoder
  p_rx_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dr && ien[IEN_RX]) |-> (iid == IID_RXD));

  // R4: acknowledging identity read drops the pending flag
  p_iid_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iid_ack |=> !tx_pend);

  // R5: acceptance restores empty status and pending flag
  p_accept_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> (thre && tx_pend && !tx_valid));

  // R6: held byte stays stable while unacknowledged
  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && tx_data == $past(tx_data)));

  // R6: holding-empty stays low while a byte is offered
  p_thre_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !thre);

  // R7: buffer read clears ready and break
  p_buf_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !rx_take) |=> (!dr && !bi));

  // R8: accepted break loads zero and flags both bits
  p_break_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && rx_break) |=> (dr && bi && rbuf == '0));

  // R8: full buffer keeps its contents
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dr && !rd_buf) |=> (dr && $stable(rbuf)));
endmodule

bind uart_regif uart_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_buf(rd_buf), .iid_ack(iid_ack),
  .rx_take(rx_take), .rx_break(rx_break), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_accept(tx_accept),
  .dr(dr), .bi(bi), .thre(thre), .tx_pend(tx_pend), .rbuf(rbuf),
  .iid(iid), .ien(ien_q)
);

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_break = 1'b0;
  logic       rx_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_break(rx_break), .rx_ready(rx_ready)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // Monitor: pops the scoreboard during each read strobe, away from the edge.
  always @(negedge clk) begin
    if (rd_en) begin
      if (sb_q.size() == 0) begin
        chk(8'hEE, 8'h00, "scoreboard underflow");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rdata, e.exp, e.tag);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    @(posedge clk); #1;
    sb_q.push_back(e);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] d, input logic brk);
    @(posedge clk); #1;
    rx_data = d; rx_break = brk; rx_valid = 1'b1;
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    chk({7'd0, irq}, 8'h00, "R10 irq after reset");
    chk({7'd0, tx_valid}, 8'h00, "R10 tx_valid after reset");
    chk({7'd0, rx_ready}, 8'h01, "R10 rx_ready after reset");
    rd(3'd5, 8'h60, "R10 line status");
    rd(3'd2, 8'h01, "R10 identity");
    rd(3'd1, 8'h00, "R10 enable");
    rd(3'd3, 8'h00, "R10 line control");
    rd(3'd4, 8'h00, "R10 modem control");
    rd(3'd6, 8'h00, "R10 modem status");
    rd(3'd7, 8'h00, "R10 scratch");

    // R11 plain registers and ignored offsets
    wr(3'd7, 8'hA5); rd(3'd7, 8'hA5, "R11 scratch");
    wr(3'd3, 8'h1B); rd(3'd3, 8'h1B, "R11 line control");
    wr(3'd4, 8'h0A); rd(3'd4, 8'h0A, "R11 modem control");
    wr(3'd6, 8'h5A); rd(3'd6, 8'h5A, "R11 modem status");
    wr(3'd5, 8'hFF); rd(3'd5, 8'h60, "R11 line status write ignored");
    wr(3'd2, 8'hFF); rd(3'd2, 8'h01, "R11 identity write ignored");

    // R1 divisor aliasing
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    chk({7'd0, tx_valid}, 8'h00, "R1 divisor write sends nothing");
    wr(3'd1, 8'h12);
    rd(3'd0, 8'h34, "R1 divisor low");
    rd(3'd1, 8'h12, "R1 divisor high");
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h00, "R1 enable untouched by divisor write");
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h02, "R1 enable readback");
    chk({7'd0, irq}, 8'h00, "R3 no tx interrupt before first send");
    wr(3'd3, 8'h83);
    rd(3'd0, 8'h34, "R1 divisor low kept");
    wr(3'd3, 8'h03);

    // R5/R6 stalled transmitter
    wr(3'd0, 8'h41);
    chk({7'd0, tx_valid}, 8'h01, "R5 tx_valid after data write");
    chk(tx_data, 8'h41, "R5 tx_data");
    rd(3'd5, 8'h40, "R6 holding-empty low while offered");
    chk({7'd0, irq}, 8'h00, "R5 pending cleared by write");
    wr(3'd0, 8'h55);
    chk(tx_data, 8'h41, "R6 write while busy dropped");
    idle(3);
    chk({7'd0, tx_valid}, 8'h01, "R6 valid held");
    @(posedge clk); #1; tx_ready = 1'b1;
    @(posedge clk); #1; tx_ready = 1'b0;
    chk({7'd0, tx_valid}, 8'h00, "R5 valid drops after accept");
    rd(3'd5, 8'h60, "R5 status after accept");
    chk({7'd0, irq}, 8'h01, "R3 tx interrupt raised");
    rd(3'd2, 8'h02, "R2 identity transmit");
    rd(3'd2, 8'h01, "R4 identity after acknowledge");
    chk({7'd0, irq}, 8'h00, "R4 irq cleared");

    // R5 ready transmitter: one-cycle handoff
    tx_ready = 1'b1;
    wr(3'd0, 8'h7E);
    chk(tx_data, 8'h7E, "R5 second byte");
    idle(1);
    chk({7'd0, tx_valid}, 8'h00, "R5 handoff done");
    chk({7'd0, irq}, 8'h01, "R3 tx interrupt again");
    tx_ready = 1'b0;

    // R8/R2/R7 receive
    wr(3'd1, 8'h03);
    rx_send(8'h3C, 1'b0);
    chk({7'd0, rx_ready}, 8'h00, "R8 rx_ready low when full");
    rd(3'd2, 8'h04, "R2 receive beats transmit");
    rx_send(8'h99, 1'b0);
    rd(3'd0, 8'h3C, "R8 full buffer ignores input / R7 read");
    rd(3'd5, 8'h60, "R7 ready cleared");
    chk({7'd0, rx_ready}, 8'h01, "R8 rx_ready after read");
    rd(3'd2, 8'h02, "R2 transmit after receive drained");
    rd(3'd2, 8'h01, "R4 acknowledge");
    rx_send(8'h77, 1'b1);
    rd(3'd5, 8'h71, "R8 break status");
    rd(3'd0, 8'h00, "R8 break loads zero");
    rd(3'd5, 8'h60, "R7 break cleared");
    rx_send(8'h11, 1'b0);
    chk({7'd0, irq}, 8'h01, "R3 receive interrupt");
    wr(3'd1, 8'h00);
    chk({7'd0, irq}, 8'h00, "R3 disabled receive source");
    rd(3'd2, 8'h01, "R3 identity when disabled");
    rd(3'd0, 8'h11, "R7 buffer byte");

    // R9 loopback
    wr(3'd4, 8'h1F); rd(3'd6, 8'hF0, "R9 loop all");
    wr(3'd4, 8'h15); rd(3'd6, 8'h60, "R9 loop out1 dtr");
    wr(3'd4, 8'h12); rd(3'd6, 8'h10, "R9 loop rts");
    wr(3'd4, 8'h18); rd(3'd6, 8'h80, "R9 loop out2");
    wr(3'd4, 8'h00); rd(3'd6, 8'h5A, "R9 stored status");

    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule